// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port with Serial Pin Takeover

This block is a small register-mapped I/O port for four pads. Software reaches three byte-wide registers over a simple bus: an output latch, a direction register and a read-only status register that shows the pad levels. The block drives a per-pin output value and output enable toward the pad ring. It also samples the pad inputs through a two-flop synchronizer before any register read-back uses them.

Reading the latch register gives a mixed view. A pin set as an output returns the latched bit, and a pin set as an input returns the synchronized pad level. The status register always returns the synchronized pad levels. On an output pin, a difference between the status bit and the latch points to a short or an overload at the pad.

A serial interface can take over the two lowest pins. While its transmitter is enabled, pin 1 becomes an output carrying the serial transmit bit. While its receiver is enabled, pin 0 becomes an input. During a takeover the latch and the direction register still accept writes. When the takeover ends, the pin goes straight back to the values held in those registers.

Top module: `gpio_port4`

## Requirements
- R1: After reset the latch and the direction register hold 0, all four `pad_oe` bits are 0, and the latch, status and direction registers all read 0.
- R2: The latch register is at offset 0x8, the status register at 0x9 and the direction register at 0xA. Any other offset reads 0x00, and a write to it changes nothing.
- R3: Only bits 3:0 exist. Bits 7:4 of every read are 0, and bits 7:4 of any written data are dropped.
- R4: A write takes effect at the rising edge of `clk` at which `bus_wr` is high. `bus_rdata` depends combinationally on `bus_addr` in the same cycle, and the direction register reads back exactly as written in bits 3:0.
- R5: A read of the latch register returns, for each bit i, the latch bit when direction bit i is 1, and synchronized pad bit i when direction bit i is 0.
- R6: A read of the status register returns the synchronized pad levels whatever the direction bits are. A write to the status register changes no register.
- R7: A change on `pad_in` first shows in `bus_rdata` and `ser_rxd` after exactly two rising edges of `clk`.
- R8: While `ser_tx_en` is 1, `pad_oe[1]` is 1 and `pad_out[1]` equals `ser_txd`.
- R9: While `ser_rx_en` is 1, `pad_oe[0]` is 0. `ser_rxd` always carries synchronized pad bit 0.
- R10: The latch takes writes during a takeover. When the takeover ends, the pin again drives the latch value under the direction bit, from the same cycle.
- R11: On a pin without an active takeover, `pad_oe[i]` equals direction bit i and `pad_out[i]` equals latch bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| pad_in | input | 4 | Pad input levels (asynchronous) |
| pad_out | output | 4 | Output value to the pads |
| pad_oe | output | 4 | Output enable to the pads, 1 = drive |
| ser_tx_en | input | 1 | Serial transmitter enabled; takes pin 1 |
| ser_rx_en | input | 1 | Serial receiver enabled; takes pin 0 |
| ser_txd | input | 1 | Serial transmit bit driven onto pin 1 |
| ser_rxd | output | 1 | Synchronized pin 0 level for the serial receiver |

## Verification
A takeover can change in the same cycle as a bus write to the latch or direction register. Either the write lands while the serial interface owns the pin, or the takeover ends at the edge where the new value is written. The bench provokes this in directed sequences and through random `ser_tx_en`/`ser_rx_en` toggles mixed with random writes. It judges pad outputs and read-back against a reference model in which register writes never depend on the takeover state. A second overlap is a pad change coinciding with a direction change. Here the latch-register read must switch sources in the cycle after the write, and it must show the synchronized level, not the raw one.

// File: rtl/gpio_port4.sv
module gpio_port4 #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int PORT_W   = 4,
  parameter int OFS_DATA = 8,
  parameter int OFS_STAT = 9,
  parameter int OFS_DIR  = 10,
  parameter int TX_PIN   = 1,
  parameter int RX_PIN   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  input  logic              ser_tx_en,
  input  logic              ser_rx_en,
  input  logic              ser_txd,
  output logic              ser_rxd
);
  localparam int PAD_HI = DATA_W - PORT_W;

  logic [PORT_W-1:0] latch_q, dir_q, sync1_q, sync2_q;
  logic              hit_data, hit_stat, hit_dir;
  logic              unused_hi;

  assign hit_data  = (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_dir   = (bus_addr == ADDR_W'(OFS_DIR));
  assign unused_hi = ^bus_wdata[DATA_W-1:PORT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (bus_wr) begin
      if (hit_data) latch_q <= bus_wdata[PORT_W-1:0];
      if (hit_dir)  dir_q   <= bus_wdata[PORT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    pad_oe  = dir_q;
    pad_out = latch_q;
    if (ser_tx_en) begin
      pad_oe[TX_PIN]  = 1'b1;
      pad_out[TX_PIN] = ser_txd;
    end
    if (ser_rx_en) pad_oe[RX_PIN] = 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_data)      bus_rdata[PORT_W-1:0] = (dir_q & latch_q) | (~dir_q & sync2_q);
    else if (hit_stat) bus_rdata[PORT_W-1:0] = sync2_q;
    else if (hit_dir)  bus_rdata[PORT_W-1:0] = dir_q;
  end

  assign ser_rxd = sync2_q[RX_PIN];

  logic [1:0] settle_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:PORT_W] == PAD_HI'(0)) else $error("upper bits set"); // R3
  AST_TX_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tx_en |-> (pad_oe[TX_PIN] && pad_out[TX_PIN] == ser_txd)) else $error("tx pin"); // R8
  AST_RX_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
    ser_rx_en |-> !pad_oe[RX_PIN]) else $error("rx pin"); // R9
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_data) |=> pad_out[PORT_W-1:2] == $past(bus_wdata[PORT_W-1:2])) else $error("latch write"); // R4
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_dir) |=> pad_oe[PORT_W-1:2] == $past(bus_wdata[PORT_W-1:2])) else $error("dir write"); // R11
  AST_STAT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd2 && hit_stat) |-> bus_rdata[PORT_W-1:0] == $past(pad_in, 2)) else $error("status latency"); // R7
  AST_STAT_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_stat && !ser_tx_en && !ser_rx_en) |=>
      (ser_tx_en || ser_rx_en || ($stable(pad_out) && $stable(pad_oe)))) else $error("status write"); // R6
endmodule

// File: tb/gpio_port4_bench.sv
`timescale 1ns/1ps
module gpio_port4_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [3:0] pad_in = 0;
  logic [3:0] pad_out, pad_oe;
  logic       ser_tx_en = 0, ser_rx_en = 0, ser_txd = 0;
  logic       ser_rxd;

  int checks = 0, fails = 0;
  logic [3:0] m_latch = 0, m_dir = 0, m_s1 = 0, m_s2 = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port4 u_gpio_port4 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .ser_tx_en(ser_tx_en),
    .ser_rx_en(ser_rx_en), .ser_txd(ser_txd), .ser_rxd(ser_rxd));

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    case (a)
      4'h8: return {4'h0, (m_dir & m_latch) | (~m_dir & m_s2)};
      4'h9: return {4'h0, m_s2};
      4'hA: return {4'h0, m_dir};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] exp_oe();
    return {m_dir[3:2], ser_tx_en ? 1'b1 : m_dir[1], ser_rx_en ? 1'b0 : m_dir[0]};
  endfunction

  function automatic logic [3:0] exp_out();
    return {m_latch[3:2], ser_tx_en ? ser_txd : m_latch[1], m_latch[0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string t;
    case (bus_addr)
      4'h8: t = "R5"; 4'h9: t = "R6"; 4'hA: t = "R4"; default: t = "R2";
    endcase
    check(t, bus_rdata, exp_rd(bus_addr));
    check("R3", {4'h0, bus_rdata[7:4]}, 8'h00);
    check("R11", {4'h0, pad_oe}, {4'h0, exp_oe()});
    check("R11", {4'h0, pad_out}, {4'h0, exp_out()});
    if (ser_tx_en) check("R8", {6'h0, pad_oe[1], pad_out[1]}, {6'h0, 1'b1, ser_txd});
    if (ser_rx_en) check("R9", {7'h0, pad_oe[0]}, 8'h00);
    check("R9", {7'h0, ser_rxd}, {7'h0, m_s2[0]});
  endtask

  task automatic cyc(input logic [3:0] a, input logic w, input logic [7:0] d,
                     input logic [3:0] pin, input logic tx, input logic rx, input logic txd);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d; pad_in = pin;
    ser_tx_en = tx; ser_rx_en = rx; ser_txd = txd;
    #1 check_all();
    @(posedge clk);
    if (w && a == 4'h8) m_latch = d[3:0];
    if (w && a == 4'hA) m_dir = d[3:0];
    m_s2 = m_s1;
    m_s1 = pin;
  endtask

  task automatic peek(input logic [3:0] a);
    @(negedge clk);
    bus_wr = 0; bus_addr = a;
    #1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    pad_in = 4'hF;
    #1 check("R1", {4'h0, pad_oe}, 8'h00);
    @(negedge clk); rst_n = 1; pad_in = 0;
    peek(4'h8); check("R1", bus_rdata, 8'h00);
    peek(4'hA); check("R1", bus_rdata, 8'h00);
    peek(4'h9); check("R1", bus_rdata, 8'h00);

    cyc(4'hA, 1, 8'hFF, 4'h0, 0, 0, 0);
    cyc(4'h8, 1, 8'hA5, 4'h0, 0, 0, 0);
    peek(4'h8); check("R3", bus_rdata, 8'h05);
    peek(4'hA); check("R4", bus_rdata, 8'h0F);

    cyc(4'h9, 1, 8'hFF, 4'h0, 0, 0, 0);
    peek(4'h8); check("R6", bus_rdata, 8'h05);
    cyc(4'h3, 1, 8'hFF, 4'h0, 0, 0, 0);
    peek(4'h3); check("R2", bus_rdata, 8'h00);
    peek(4'hA); check("R2", bus_rdata, 8'h0F);

    cyc(4'h9, 0, 0, 4'hA, 0, 0, 0);
    peek(4'h9); check("R7", bus_rdata, 8'h00);
    @(posedge clk); m_s2 = m_s1; m_s1 = 4'hA;
    peek(4'h9); check("R7", bus_rdata, 8'h0A);
    check("R6", bus_rdata, 8'h0A);
    peek(4'h8); check("R5", bus_rdata, 8'h05);

    cyc(4'hA, 1, 8'h00, 4'hA, 0, 0, 0);
    peek(4'h8); check("R5", bus_rdata, 8'h0A);

    cyc(4'hA, 1, 8'h03, 4'hA, 1, 1, 0);
    cyc(4'h8, 1, 8'h02, 4'hA, 1, 1, 0);
    cyc(4'h8, 0, 0, 4'hA, 1, 1, 1);
    cyc(4'h8, 0, 0, 4'hA, 0, 0, 0);
    check("R10", {4'h0, pad_out}, 8'h02);
    check("R10", {4'h0, pad_oe}, 8'h03);

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      case ($urandom % 5)
        0: a = 4'h8; 1: a = 4'h9; 2: a = 4'hA; default: a = 4'($urandom);
      endcase
      cyc(a, 1'($urandom), 8'($urandom), 4'($urandom),
          ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule